// File: doc/BRIEF.md
# Queue Status and Interrupt Controller

This block gathers the condition flags of sixty-four hardware queues and presents them to software as packed 32-bit status words. It also turns selected conditions into two interrupt lines, one for each half of the queue space. Queues 0 to 31 form the lower half. Queues 32 to 63 form the upper half. The FIFO storage and the watermark logic sit elsewhere. They deliver six flags per queue every cycle: empty, nearly empty, nearly full, full, underflow and overflow.

The two halves are treated differently. Each lower-half queue has a full four-bit status field and a two-bit error field. Each also has a programmable three-bit selector that chooses which condition sets its interrupt-status bit. Each upper-half queue has only one bit in a nearly-empty word and one bit in a full word. Its interrupt condition is fixed to "not nearly empty". Both halves have an enable word and a write-one-to-clear status word, and each half drives its own line. The register port is a plain single-cycle port: a write happens on the clock edge when `reg_we` is high, and `reg_rdata` follows `reg_addr` combinationally. No data stream passes through the block, so there is no back-pressure.

Top module: `qstat_irq_ctrl`

## Requirements
- R1: Word addresses 0 to 3 read the lower-half condition status. Queue q sits in word q>>3 at bit (q&7)*4. Within that nibble, bit 0 is empty, bit 1 is nearly empty, bit 2 is nearly full and bit 3 is full.
- R2: Word addresses 4 and 5 read the lower-half error status. Queue q sits in word 4+(q>>4) at bit (q&15)*2. Bit 0 is underflow and bit 1 is overflow.
- R3: Address 6 reads the nearly-empty flags of the upper half. Address 7 reads their full flags. Queue q sits at bit q-32 in both words.
- R4: Addresses 8 to 11 hold the lower-half source selectors. Queue q sits in word 8+(q>>3), with its selector in bits (q&7)*4+2 down to (q&7)*4. The bit above each selector is reserved: it reads 0 and ignores writes. The selector values are 0 empty, 1 nearly empty, 2 nearly full, 3 full, 4 not empty, 5 not nearly empty, 6 not nearly full and 7 not full.
- R5: A lower-half status bit (address 14, bit q) is set on any clock edge where that queue's selected condition is true. It stays set until it is cleared, whatever its enable bit holds.
- R6: An upper-half status bit (address 15, bit q-32) is set on any clock edge where that queue's nearly-empty flag is low. No write can change this condition.
- R7: Writing to a status word clears the bits written as 1 and leaves the bits written as 0 unchanged. If the condition is true on the same edge as the clear, the bit stays set.
- R8: `irq_lo` is high exactly when some lower-half status bit and its enable bit (address 12) are both 1. `irq_hi` does the same with the upper-half status and enable (address 13).
- R9: After reset, all enable, status and selector bits are 0 and both interrupt lines are low.
- R10: Addresses 16 to 31 read as 0, and writes to them change no state.
- R11: Each enable word can be written and read back. It changes only when its own address is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_empty | input | 64 | Empty flag for each queue |
| q_nearly_empty | input | 64 | Nearly-empty flag for each queue |
| q_nearly_full | input | 64 | Nearly-full flag for each queue |
| q_full | input | 64 | Full flag for each queue |
| q_underflow | input | 64 | Underflow flag (lower half used) |
| q_overflow | input | 64 | Overflow flag (lower half used) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq_lo | output | 1 | Interrupt for queues 0 to 31 |
| irq_hi | output | 1 | Interrupt for queues 32 to 63 |

## Verification
The bench sweeps all eight selector codes, with each condition both true and false. An inverted or reordered encoding would therefore set a status bit that should stay clear, or miss one that should be set. It checks the nibble and pair positions of chosen queues away from queue 0, which exposes a wrong shift or word index in the packing. The bench clears a status bit while its condition is still true: a design that gives the clear priority would drop that bit. It also writes ones to the reserved selector bits and to unmapped addresses. A design that stored those bits or decoded those addresses loosely would read back the wrong value or corrupt an enable word.

// File: rtl/qsi_pkg.sv
package qsi_pkg;
  localparam int HALF_Q   = 32;
  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 5;
  localparam int SEL_W    = 3;
  localparam int PRI_WRDS = HALF_Q * 4 / WORD_W;
  localparam int SEC_WRDS = HALF_Q * 2 / WORD_W;
  localparam int SEL_WRDS = HALF_Q * 4 / WORD_W;

  localparam int A_PRI    = 0;
  localparam int A_SEC    = A_PRI + PRI_WRDS;
  localparam int A_UPNE   = A_SEC + SEC_WRDS;
  localparam int A_UPF    = A_UPNE + 1;
  localparam int A_SEL    = A_UPF + 1;
  localparam int A_EN_LO  = A_SEL + SEL_WRDS;
  localparam int A_EN_HI  = A_EN_LO + 1;
  localparam int A_ST_LO  = A_EN_HI + 1;
  localparam int A_ST_HI  = A_ST_LO + 1;

  typedef enum logic [SEL_W-1:0] {
    SRC_EMPTY      = 3'd0,
    SRC_NEMPTY     = 3'd1,
    SRC_NFULL      = 3'd2,
    SRC_FULL       = 3'd3,
    SRC_NOT_EMPTY  = 3'd4,
    SRC_NOT_NEMPTY = 3'd5,
    SRC_NOT_NFULL  = 3'd6,
    SRC_NOT_FULL   = 3'd7
  } src_sel_e;

  typedef struct packed {
    logic full;
    logic nfull;
    logic nempty;
    logic empty;
  } qflags_t;

  function automatic logic pick_cond(src_sel_e s, qflags_t f);
    logic base;
    case (s[1:0])
      2'd0:    base = f.empty;
      2'd1:    base = f.nempty;
      2'd2:    base = f.nfull;
      default: base = f.full;
    endcase
    return s[2] ? ~base : base;
  endfunction
endpackage

// File: rtl/qsi_sel_regs.sv
module qsi_sel_regs
  import qsi_pkg::*;
#(
  parameter int NQ = HALF_Q
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [NQ*SEL_W-1:0] sel_flat
);
  localparam int PER_WORD = WORD_W / 4;

  for (genvar q = 0; q < NQ; q++) begin : g_sel
    localparam int WRD = q / PER_WORD;
    localparam int OFS = (q % PER_WORD) * 4;
    logic [SEL_W-1:0] sel_q;
    logic             hit;
    assign hit = reg_we && (reg_addr == ADDR_W'(A_SEL + WRD));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sel_q <= '0;
      else if (hit) sel_q <= reg_wdata[OFS +: SEL_W];
    end
    assign sel_flat[q*SEL_W +: SEL_W] = sel_q;
  end

  logic unused_rsv;
  assign unused_rsv = ^{reg_wdata[31], reg_wdata[27], reg_wdata[23], reg_wdata[19],
                        reg_wdata[15], reg_wdata[11], reg_wdata[7], reg_wdata[3]};
endmodule

// File: rtl/qsi_cond_sel.sv
module qsi_cond_sel
  import qsi_pkg::*;
#(
  parameter int NQ = HALF_Q
) (
  input  logic [NQ*SEL_W-1:0] sel_flat,
  input  logic [NQ-1:0]       empty,
  input  logic [NQ-1:0]       nempty,
  input  logic [NQ-1:0]       nfull,
  input  logic [NQ-1:0]       full,
  output logic [NQ-1:0]       cond
);
  for (genvar q = 0; q < NQ; q++) begin : g_q
    qflags_t f;
    assign f = '{full: full[q], nfull: nfull[q], nempty: nempty[q], empty: empty[q]};
    assign cond[q] = pick_cond(src_sel_e'(sel_flat[q*SEL_W +: SEL_W]), f);
  end
endmodule

// File: rtl/qsi_irq_half.sv
module qsi_irq_half #(
  parameter int NQ = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] cond,
  input  logic          en_we,
  input  logic          st_we,
  input  logic [NQ-1:0] wdata,
  output logic [NQ-1:0] en,
  output logic [NQ-1:0] stat,
  output logic          irq
);
  logic [NQ-1:0] clr_mask;
  assign clr_mask = st_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= '0;
      stat <= '0;
    end else begin
      if (en_we) en <= wdata;
      stat <= (stat & ~clr_mask) | cond;
    end
  end

  assign irq = |(stat & en);

  // R5 / R6: a bit only rises where its condition was seen true
  assert_set_only_on_cond_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ~$past(stat) & ~$past(cond)) == '0));

  // R7: a bit only falls where a one was written to it
  assert_clear_only_by_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat) & ~stat & ~$past(clr_mask)) == '0));

  // R11: enable holds unless written
  assert_enable_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_we) |-> (en == $past(en)));

  // R8: the line never rises with no enable bit set
  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en != '0));
endmodule

// File: rtl/qstat_irq_ctrl.sv
module qstat_irq_ctrl
  import qsi_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*HALF_Q-1:0] q_empty,
  input  logic [2*HALF_Q-1:0] q_nearly_empty,
  input  logic [2*HALF_Q-1:0] q_nearly_full,
  input  logic [2*HALF_Q-1:0] q_full,
  input  logic [2*HALF_Q-1:0] q_underflow,
  input  logic [2*HALF_Q-1:0] q_overflow,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic                irq_lo,
  output logic                irq_hi
);
  localparam int LO = 0;
  localparam int HI = HALF_Q;

  logic [HALF_Q*SEL_W-1:0] sel_flat;
  logic [HALF_Q-1:0]       cond_lo, cond_hi;
  logic [HALF_Q-1:0]       en_lo, en_hi, st_lo, st_hi;
  logic [HALF_Q*4-1:0]     pri_flat;
  logic [HALF_Q*2-1:0]     sec_flat;
  logic [HALF_Q*4-1:0]     selrd_flat;

  qsi_sel_regs #(.NQ(HALF_Q)) u_sel (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sel_flat(sel_flat)
  );

  qsi_cond_sel #(.NQ(HALF_Q)) u_cond (
    .sel_flat(sel_flat),
    .empty (q_empty[LO +: HALF_Q]),
    .nempty(q_nearly_empty[LO +: HALF_Q]),
    .nfull (q_nearly_full[LO +: HALF_Q]),
    .full  (q_full[LO +: HALF_Q]),
    .cond  (cond_lo)
  );

  assign cond_hi = ~q_nearly_empty[HI +: HALF_Q];

  qsi_irq_half #(.NQ(HALF_Q)) u_half_lo (
    .clk(clk), .rst_n(rst_n), .cond(cond_lo),
    .en_we(reg_we && reg_addr == ADDR_W'(A_EN_LO)),
    .st_we(reg_we && reg_addr == ADDR_W'(A_ST_LO)),
    .wdata(reg_wdata), .en(en_lo), .stat(st_lo), .irq(irq_lo)
  );

  qsi_irq_half #(.NQ(HALF_Q)) u_half_hi (
    .clk(clk), .rst_n(rst_n), .cond(cond_hi),
    .en_we(reg_we && reg_addr == ADDR_W'(A_EN_HI)),
    .st_we(reg_we && reg_addr == ADDR_W'(A_ST_HI)),
    .wdata(reg_wdata), .en(en_hi), .stat(st_hi), .irq(irq_hi)
  );

  for (genvar q = 0; q < HALF_Q; q++) begin : g_pack
    assign pri_flat[q*4 +: 4]   = {q_full[q], q_nearly_full[q], q_nearly_empty[q], q_empty[q]};
    assign sec_flat[q*2 +: 2]   = {q_overflow[q], q_underflow[q]};
    assign selrd_flat[q*4 +: 4] = {1'b0, sel_flat[q*SEL_W +: SEL_W]};
  end

  logic unused_hi_err;
  assign unused_hi_err = ^{q_underflow[HI +: HALF_Q], q_overflow[HI +: HALF_Q],
                           q_empty[HI +: HALF_Q], q_nearly_full[HI +: HALF_Q]};

  always_comb begin
    int a;
    a = int'(reg_addr);
    reg_rdata = '0;
    if (a < A_SEC)                    reg_rdata = pri_flat[(a - A_PRI)*WORD_W +: WORD_W];
    else if (a < A_UPNE)              reg_rdata = sec_flat[(a - A_SEC)*WORD_W +: WORD_W];
    else if (a == A_UPNE)             reg_rdata = q_nearly_empty[HI +: HALF_Q];
    else if (a == A_UPF)              reg_rdata = q_full[HI +: HALF_Q];
    else if (a < A_EN_LO)             reg_rdata = selrd_flat[(a - A_SEL)*WORD_W +: WORD_W];
    else if (a == A_EN_LO)            reg_rdata = en_lo;
    else if (a == A_EN_HI)            reg_rdata = en_hi;
    else if (a == A_ST_LO)            reg_rdata = st_lo;
    else if (a == A_ST_HI)            reg_rdata = st_hi;
  end

  // R4: reserved selector bits always read back as zero
  assert_rsv_bits_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr >= ADDR_W'(A_SEL) && reg_addr < ADDR_W'(A_EN_LO)) |->
      ((reg_rdata & 32'h8888_8888) == '0));

  // R10: unmapped addresses read zero
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > ADDR_W'(A_ST_HI)) |-> (reg_rdata == '0));
endmodule

// File: tb/qstat_irq_ctrl_bench.sv
module qstat_irq_ctrl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] fe = '0, fne = '1, fnf = '0, ff = '0, fu = '0, fo = '0;
  logic        reg_we = 0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_lo, irq_hi;
  int          checks = 0, fails = 0;
  logic        done = 0;

  always #5 clk = ~clk;

  qstat_irq_ctrl u_qstat_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .q_empty(fe), .q_nearly_empty(fne),
    .q_nearly_full(fnf), .q_full(ff), .q_underflow(fu), .q_overflow(fo),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // {sel[7:5], full, nfull, nempty, empty, expected}
  localparam logic [7:0] VEC [16] = '{
    {3'd0, 4'b0001, 1'b1}, {3'd0, 4'b1110, 1'b0},
    {3'd1, 4'b0010, 1'b1}, {3'd1, 4'b1101, 1'b0},
    {3'd2, 4'b0100, 1'b1}, {3'd2, 4'b1011, 1'b0},
    {3'd3, 4'b1000, 1'b1}, {3'd3, 4'b0111, 1'b0},
    {3'd4, 4'b0000, 1'b1}, {3'd4, 4'b0001, 1'b0},
    {3'd5, 4'b0000, 1'b1}, {3'd5, 4'b0010, 1'b0},
    {3'd6, 4'b0000, 1'b1}, {3'd6, 4'b0100, 1'b0},
    {3'd7, 4'b0000, 1'b1}, {3'd7, 4'b1000, 1'b0}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rchk(string req, logic [4:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) tick();
    rst_n = 1;
    tick();

    // R9: reset state
    rchk("R9 en_lo", 5'd12, 32'h0);
    rchk("R9 en_hi", 5'd13, 32'h0);
    rchk("R9 st_lo", 5'd14, 32'h0);
    rchk("R9 st_hi", 5'd15, 32'h0);
    rchk("R9 sel", 5'd8, 32'h0);
    chk("R9 irq", {30'd0, irq_hi, irq_lo}, 32'h0);
    rchk("R1 idle word", 5'd0, 32'h2222_2222);

    // R4 R5: selector encodings walked on queue 0
    for (int i = 0; i < 16; i++) begin
      fe[0] = VEC[i][1]; fne[0] = VEC[i][2]; fnf[0] = VEC[i][3]; ff[0] = VEC[i][4];
      wr(5'd8, {29'd0, VEC[i][7:5]});
      wr(5'd14, 32'h1);
      tick();
      rd(5'd14, d);
      chk($sformatf("R5 R4 vec%0d sel=%0d", i, VEC[i][7:5]), d, {31'd0, VEC[i][0]});
    end
    fe[0] = 0; fne[0] = 1; fnf[0] = 0; ff[0] = 0;
    wr(5'd8, 32'h0);
    wr(5'd14, 32'hFFFF_FFFF);
    rchk("R7 cleared after walk", 5'd14, 32'h0);

    // R1 R2 R3: packing
    fnf[13] = 1; ff[13] = 1; fne[13] = 0;
    fu[13] = 1; fo[20] = 1;
    fne[40] = 0; ff[63] = 1;
    rchk("R1 q13 word1", 5'd1, 32'h22C2_2222);
    rchk("R2 q13 underflow", 5'd4, 32'h0400_0000);
    rchk("R2 q20 overflow", 5'd5, 32'h0000_0200);
    rchk("R3 upper nearly empty", 5'd6, 32'hFFFF_FEFF);
    rchk("R3 upper full", 5'd7, 32'h8000_0000);
    fnf[13] = 0; ff[13] = 0; fne[13] = 1; fu[13] = 0; fo[20] = 0; ff[63] = 0;

    // R6 R8: upper fixed condition and line
    tick();
    rchk("R6 upper status", 5'd15, 32'h0000_0100);
    chk("R8 irq_hi masked", {31'd0, irq_hi}, 32'h0);
    wr(5'd13, 32'h0000_0100);
    rchk("R11 en_hi readback", 5'd13, 32'h0000_0100);
    chk("R8 irq_hi raised", {31'd0, irq_hi}, 32'h1);
    chk("R8 irq_lo quiet", {31'd0, irq_lo}, 32'h0);
    fne[40] = 1;
    tick();
    rchk("R5 sticky upper", 5'd15, 32'h0000_0100);
    wr(5'd15, 32'h0);
    rchk("R7 zero write no effect", 5'd15, 32'h0000_0100);
    wr(5'd15, 32'h0000_0100);
    rchk("R7 upper cleared", 5'd15, 32'h0);
    chk("R8 irq_hi dropped", {31'd0, irq_hi}, 32'h0);

    // R5 R8 R7: lower queue 3 on full
    wr(5'd8, 32'h0000_3000);
    wr(5'd12, 32'h0000_0008);
    ff[3] = 1;
    tick();
    rchk("R5 q3 full status", 5'd14, 32'h0000_0008);
    chk("R8 irq_lo raised", {31'd0, irq_lo}, 32'h1);
    wr(5'd12, 32'h0);
    chk("R8 irq_lo masked", {31'd0, irq_lo}, 32'h0);
    rchk("R5 status kept while masked", 5'd14, 32'h0000_0008);
    wr(5'd14, 32'h0000_0008);
    rchk("R7 set beats clear", 5'd14, 32'h0000_0008);
    ff[3] = 0;
    wr(5'd14, 32'h0000_0008);
    rchk("R7 lower cleared", 5'd14, 32'h0);

    // R10: unmapped
    wr(5'd12, 32'h0000_00F0);
    wr(5'd20, 32'hFFFF_FFFF);
    rchk("R10 unmapped reads zero", 5'd20, 32'h0);
    rchk("R10 en_lo untouched", 5'd12, 32'h0000_00F0);
    rchk("R10 sel untouched", 5'd8, 32'h0000_3000);

    // R4: reserved bits
    wr(5'd12, 32'h0);
    wr(5'd9, 32'hFFFF_FFFF);
    rchk("R4 reserved bits read zero", 5'd9, 32'h7777_7777);
    wr(5'd9, 32'h0);
    wr(5'd14, 32'hFFFF_FFFF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule